// File: doc/BRIEF.md
# Register Window Occupancy Controller

This block keeps the bookkeeping for a processor whose integer registers are arranged as a ring of overlapping windows. It holds the pointer to the active window, the number of windows that can still be entered by a save, the number that can be left by a restore, the clean-window count, the count of windows owned by another context, and a 6-bit field of two trap-type selectors. The register storage itself lives elsewhere. This block only decides, for each request, where the pointer goes and whether the request finishes or traps.

Each accepted request is a save, a restore, a flush of all windows, or a load of the whole state. A load is the path by which a trap handler or a context switch writes the state. The pointer move is committed even when the request traps. All results are registered and appear in the cycle after the request.

Top module: `rwin_ctrl`

## Requirements
- R1: After a synchronous active-high reset, the pointer, can-restore, clean-window and other-windows counts and the state field are 0, can-save is NWIN-2, and trap_valid and rd_we are 0.
- R2: A save (req_op=0) when can-save is 0 raises a spill trap (trap_kind=1), moves the pointer forward by 2 modulo NWIN, leaves the counts unchanged and does not assert rd_we.
- R3: A save when can-save is nonzero and the clean-window count equals can-restore raises a clean-window trap (trap_kind=3, trap_type=0), moves the pointer forward by 1 and leaves the counts unchanged.
- R4: Any other save moves the pointer forward by 1, decrements can-save, increments can-restore and asserts rd_we for one cycle without a trap.
- R5: A restore (req_op=1) always moves the pointer back by 1 modulo NWIN. When can-restore is 0 it raises a fill trap (trap_kind=2) and leaves the counts unchanged.
- R6: A restore when can-restore is nonzero increments can-save, decrements can-restore and asserts rd_we without a trap.
- R7: For spill and fill traps, trap_type is state bits [5:3] when the other-windows count is nonzero, and state bits [2:0] when it is zero.
- R8: A flush (req_op=2) raises a spill trap when can-save equals NWIN-2. Otherwise it does nothing. In neither case does it move the pointer or change a count.
- R9: trap_valid lasts exactly the one cycle that follows the trapping request. trap_kind is 0 whenever no trap is reported. Cycles without a request report no trap and no write.
- R10: A load (req_op=3) copies all six load inputs into the state in one cycle, with no trap and no write.
- R11: The pointer always stays below NWIN and wraps correctly in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 2 | 0 save, 1 restore, 2 flush, 3 load |
| ld_cwp | input | CW | Pointer value for a load |
| ld_cansave | input | CW | Can-save value for a load |
| ld_canrestore | input | CW | Can-restore value for a load |
| ld_cleanwin | input | CW | Clean-window value for a load |
| ld_otherwin | input | CW | Other-windows value for a load |
| ld_wstate | input | 6 | Trap-type selector field for a load |
| cwp | output | CW | Current window pointer |
| cansave | output | CW | Windows available to save |
| canrestore | output | CW | Windows available to restore |
| cleanwin | output | CW | Clean-window count |
| otherwin | output | CW | Other-windows count |
| wstate | output | 6 | Trap-type selector field |
| trap_valid | output | 1 | One-cycle trap report |
| trap_kind | output | 2 | 0 none, 1 spill, 2 fill, 3 clean |
| trap_type | output | 3 | Selected trap type |
| rd_we | output | 1 | Destination register write enable |

## Verification
The hardest state to reach from the ports is a save that finds can-save at zero while the other-windows count is nonzero, because saves from reset run into clean-window traps long before can-save drains. The stimulus therefore uses load requests to place the counters directly at each boundary: can-save at zero, can-restore at zero, can-save at NWIN-2, and the pointer next to the wrap point. It then follows each load with the request under test. A long run of mixed loads and operations is compared against a behavioural model on every cycle.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
  typedef enum logic [1:0] {
    OP_SAVE    = 2'd0,
    OP_RESTORE = 2'd1,
    OP_FLUSH   = 2'd2,
    OP_LOAD    = 2'd3
  } rwin_op_e;

  typedef enum logic [1:0] {
    TK_NONE  = 2'd0,
    TK_SPILL = 2'd1,
    TK_FILL  = 2'd2,
    TK_CLEAN = 2'd3
  } rwin_kind_e;
endpackage

// File: rtl/rwin_mod_step.sv
module rwin_mod_step #(
  parameter int NWIN = 8,
  parameter int CW   = $clog2(NWIN)
) (
  input  logic [CW-1:0] cur,
  output logic [CW-1:0] plus1,
  output logic [CW-1:0] plus2,
  output logic [CW-1:0] minus1
);
  localparam logic [CW:0]   NW_W = (CW+1)'(NWIN);
  localparam logic [CW-1:0] TOP  = CW'(NWIN - 1);

  generate
    if ((NWIN & (NWIN - 1)) == 0) begin : gen_pow2
      // ring size equals the counter range: wrap for free
      assign plus1  = cur + CW'(1);
      assign plus2  = cur + CW'(2);
      assign minus1 = cur - CW'(1);
    end else begin : gen_any
      logic [CW:0] s1, s2;
      assign s1     = {1'b0, cur} + (CW+1)'(1);
      assign s2     = {1'b0, cur} + (CW+1)'(2);
      assign plus1  = (s1 >= NW_W) ? CW'(s1 - NW_W) : CW'(s1);
      assign plus2  = (s2 >= NW_W) ? CW'(s2 - NW_W) : CW'(s2);
      assign minus1 = (cur == '0) ? TOP : cur - CW'(1);
    end
  endgenerate
endmodule

// File: rtl/rwin_trap_sel.sv
module rwin_trap_sel #(
  parameter int CW = 3
) (
  input  logic [CW-1:0] otherwin,
  input  logic [5:0]    wstate,
  output logic [2:0]    ttype
);
  // the upper selector serves windows owned by another context
  assign ttype = (otherwin != '0) ? wstate[5:3] : wstate[2:0];
endmodule

// File: rtl/rwin_decide.sv
module rwin_decide
  import rwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int CW   = $clog2(NWIN)
) (
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [CW-1:0] cwp,
  input  logic [CW-1:0] cansave,
  input  logic [CW-1:0] canrestore,
  input  logic [CW-1:0] cleanwin,
  input  logic [CW-1:0] otherwin,
  input  logic [5:0]    wstate,
  input  logic [CW-1:0] ld_cwp,
  input  logic [CW-1:0] ld_cansave,
  input  logic [CW-1:0] ld_canrestore,
  input  logic [CW-1:0] ld_cleanwin,
  input  logic [CW-1:0] ld_otherwin,
  input  logic [5:0]    ld_wstate,
  output logic [CW-1:0] n_cwp,
  output logic [CW-1:0] n_cansave,
  output logic [CW-1:0] n_canrestore,
  output logic [CW-1:0] n_cleanwin,
  output logic [CW-1:0] n_otherwin,
  output logic [5:0]    n_wstate,
  output logic          n_tv,
  output rwin_kind_e    n_kind,
  output logic [2:0]    n_type,
  output logic          n_we
);
  localparam logic [CW-1:0] FULL_SAVE = CW'(NWIN - 2);

  logic [CW-1:0] p1, p2, m1;
  logic [2:0]    sel_type;
  rwin_op_e      op;

  rwin_mod_step #(.NWIN(NWIN), .CW(CW)) u_step (
    .cur(cwp), .plus1(p1), .plus2(p2), .minus1(m1)
  );

  rwin_trap_sel #(.CW(CW)) u_sel (
    .otherwin(otherwin), .wstate(wstate), .ttype(sel_type)
  );

  assign op = rwin_op_e'(req_op);

  always_comb begin
    n_cwp        = cwp;
    n_cansave    = cansave;
    n_canrestore = canrestore;
    n_cleanwin   = cleanwin;
    n_otherwin   = otherwin;
    n_wstate     = wstate;
    n_tv         = 1'b0;
    n_kind       = TK_NONE;
    n_type       = 3'd0;
    n_we         = 1'b0;
    if (req_valid) begin
      case (op)
        OP_SAVE: begin
          if (cansave == '0) begin
            n_cwp  = p2;
            n_tv   = 1'b1;
            n_kind = TK_SPILL;
            n_type = sel_type;
          end else if (cleanwin == canrestore) begin
            n_cwp  = p1;
            n_tv   = 1'b1;
            n_kind = TK_CLEAN;
          end else begin
            n_cwp        = p1;
            n_cansave    = cansave - CW'(1);
            n_canrestore = canrestore + CW'(1);
            n_we         = 1'b1;
          end
        end
        OP_RESTORE: begin
          n_cwp = m1;
          if (canrestore == '0) begin
            n_tv   = 1'b1;
            n_kind = TK_FILL;
            n_type = sel_type;
          end else begin
            n_cansave    = cansave + CW'(1);
            n_canrestore = canrestore - CW'(1);
            n_we         = 1'b1;
          end
        end
        OP_FLUSH: begin
          if (cansave == FULL_SAVE) begin
            n_tv   = 1'b1;
            n_kind = TK_SPILL;
            n_type = sel_type;
          end
        end
        default: begin
          n_cwp        = ld_cwp;
          n_cansave    = ld_cansave;
          n_canrestore = ld_canrestore;
          n_cleanwin   = ld_cleanwin;
          n_otherwin   = ld_otherwin;
          n_wstate     = ld_wstate;
        end
      endcase
    end
  end
endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl
  import rwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int CW   = $clog2(NWIN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [CW-1:0] ld_cwp,
  input  logic [CW-1:0] ld_cansave,
  input  logic [CW-1:0] ld_canrestore,
  input  logic [CW-1:0] ld_cleanwin,
  input  logic [CW-1:0] ld_otherwin,
  input  logic [5:0]    ld_wstate,
  output logic [CW-1:0] cwp,
  output logic [CW-1:0] cansave,
  output logic [CW-1:0] canrestore,
  output logic [CW-1:0] cleanwin,
  output logic [CW-1:0] otherwin,
  output logic [5:0]    wstate,
  output logic          trap_valid,
  output logic [1:0]    trap_kind,
  output logic [2:0]    trap_type,
  output logic          rd_we
);
  logic [CW-1:0] n_cwp, n_cs, n_cr, n_cl, n_ow;
  logic [5:0]    n_ws;
  logic          n_tv, n_we;
  rwin_kind_e    n_kind;
  logic [2:0]    n_type;

  rwin_decide #(.NWIN(NWIN), .CW(CW)) u_decide (
    .req_valid(req_valid), .req_op(req_op),
    .cwp(cwp), .cansave(cansave), .canrestore(canrestore),
    .cleanwin(cleanwin), .otherwin(otherwin), .wstate(wstate),
    .ld_cwp(ld_cwp), .ld_cansave(ld_cansave), .ld_canrestore(ld_canrestore),
    .ld_cleanwin(ld_cleanwin), .ld_otherwin(ld_otherwin), .ld_wstate(ld_wstate),
    .n_cwp(n_cwp), .n_cansave(n_cs), .n_canrestore(n_cr),
    .n_cleanwin(n_cl), .n_otherwin(n_ow), .n_wstate(n_ws),
    .n_tv(n_tv), .n_kind(n_kind), .n_type(n_type), .n_we(n_we)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cwp        <= '0;
      cansave    <= CW'(NWIN - 2);
      canrestore <= '0;
      cleanwin   <= '0;
      otherwin   <= '0;
      wstate     <= '0;
      trap_valid <= 1'b0;
      trap_kind  <= TK_NONE;
      trap_type  <= 3'd0;
      rd_we      <= 1'b0;
    end else begin
      cwp        <= n_cwp;
      cansave    <= n_cs;
      canrestore <= n_cr;
      cleanwin   <= n_cl;
      otherwin   <= n_ow;
      wstate     <= n_ws;
      trap_valid <= n_tv;
      trap_kind  <= n_kind;
      trap_type  <= n_type;
      rd_we      <= n_we;
    end
  end

  assert_cwp_bound_R11: assert property (@(posedge clk) disable iff (rst)
    int'(cwp) < NWIN);

  assert_spill_step_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == OP_SAVE && cansave == '0) |=>
      (trap_kind == TK_SPILL && int'(cwp) == (int'($past(cwp)) + 2) % NWIN
       && $stable(cansave) && !rd_we));

  assert_restore_step_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == OP_RESTORE) |=>
      (int'(cwp) == (int'($past(cwp)) + NWIN - 1) % NWIN));

  assert_restore_ok_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == OP_RESTORE && canrestore != '0) |=>
      (rd_we && int'(cansave) == int'($past(cansave)) + 1));

  assert_flush_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == OP_FLUSH) |=> ($stable(cwp) && $stable(cansave)));

  assert_we_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(rd_we && trap_valid));

  assert_kind_match_R9: assert property (@(posedge clk) disable iff (rst)
    trap_valid == (trap_kind != TK_NONE));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!trap_valid && !rd_we));
endmodule

// File: tb/rwin_ctrl_bench.sv
module rwin_ctrl_bench;
  localparam int N  = 8;
  localparam int CW = 3;

  logic clk = 0;
  logic rst = 1;
  logic req_valid = 0;
  logic [1:0] req_op = 0;
  logic [CW-1:0] ld_cwp = 0, ld_cs = 0, ld_cr = 0, ld_cl = 0, ld_ow = 0;
  logic [5:0] ld_ws = 0;
  logic [CW-1:0] cwp, cansave, canrestore, cleanwin, otherwin;
  logic [5:0] wstate;
  logic trap_valid, rd_we;
  logic [1:0] trap_kind;
  logic [2:0] trap_type;

  int checks = 0, failures = 0;
  int m_cwp, m_cs, m_cr, m_cl, m_ow, m_ws, m_tv, m_kind, m_type, m_we;
  string tag;

  always #10 clk = ~clk;

  rwin_ctrl #(.NWIN(N)) u_rwin_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .ld_cwp(ld_cwp), .ld_cansave(ld_cs), .ld_canrestore(ld_cr),
    .ld_cleanwin(ld_cl), .ld_otherwin(ld_ow), .ld_wstate(ld_ws),
    .cwp(cwp), .cansave(cansave), .canrestore(canrestore),
    .cleanwin(cleanwin), .otherwin(otherwin), .wstate(wstate),
    .trap_valid(trap_valid), .trap_kind(trap_kind), .trap_type(trap_type),
    .rd_we(rd_we)
  );

  task automatic compare();
    checks++;
    if (int'(cwp) != m_cwp || int'(cansave) != m_cs || int'(canrestore) != m_cr ||
        int'(cleanwin) != m_cl || int'(otherwin) != m_ow || int'(wstate) != m_ws ||
        int'(trap_valid) != m_tv || int'(trap_kind) != m_kind ||
        int'(trap_type) != m_type || int'(rd_we) != m_we) begin
      failures++;
      $display("FAIL %s actual cwp=%0d cs=%0d cr=%0d cl=%0d ow=%0d ws=%0d tv=%0d kind=%0d type=%0d we=%0d expected cwp=%0d cs=%0d cr=%0d cl=%0d ow=%0d ws=%0d tv=%0d kind=%0d type=%0d we=%0d",
        tag, cwp, cansave, canrestore, cleanwin, otherwin, wstate, trap_valid,
        trap_kind, trap_type, rd_we, m_cwp, m_cs, m_cr, m_cl, m_ow, m_ws,
        m_tv, m_kind, m_type, m_we);
    end
  endtask

  function automatic int sel_type();
    return (m_ow != 0) ? (m_ws >> 3) & 7 : m_ws & 7;
  endfunction

  // behavioural reference: one request, applied at the coming edge
  task automatic model(input bit v, input int op);
    m_tv = 0; m_kind = 0; m_type = 0; m_we = 0;
    if (!v) tag = "R9 idle";
    else if (op == 0) begin
      if (m_cs == 0) begin
        m_type = sel_type(); m_cwp = (m_cwp + 2) % N; m_tv = 1; m_kind = 1;
        tag = "R2 R7 spill-on-save";
      end else if (m_cl == m_cr) begin
        m_cwp = (m_cwp + 1) % N; m_tv = 1; m_kind = 3; tag = "R3 clean";
      end else begin
        m_cwp = (m_cwp + 1) % N; m_cs--; m_cr++; m_we = 1; tag = "R4 R11 save";
      end
    end else if (op == 1) begin
      m_cwp = (m_cwp + N - 1) % N;
      if (m_cr == 0) begin
        m_tv = 1; m_kind = 2; m_type = sel_type(); tag = "R5 R7 fill";
      end else begin
        m_cs++; m_cr--; m_we = 1; tag = "R6 R11 restore";
      end
    end else if (op == 2) begin
      tag = "R8 flush";
      if (N - 2 - m_cs == 0) begin m_tv = 1; m_kind = 1; m_type = sel_type(); end
    end else begin
      m_cwp = ld_cwp; m_cs = ld_cs; m_cr = ld_cr; m_cl = ld_cl; m_ow = ld_ow;
      m_ws = ld_ws; tag = "R10 load";
    end
  endtask

  task automatic step(input bit v, input int op);
    req_valid = v;
    req_op = 2'(op);
    model(v, op);
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic load(input int c, input int s, input int r, input int l,
                      input int o, input int w);
    ld_cwp = CW'(c); ld_cs = CW'(s); ld_cr = CW'(r); ld_cl = CW'(l);
    ld_ow = CW'(o); ld_ws = 6'(w);
    step(1, 3);
  endtask

  initial begin
    #4000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    m_cwp = 0; m_cs = N - 2; m_cr = 0; m_cl = 0; m_ow = 0; m_ws = 0;
    m_tv = 0; m_kind = 0; m_type = 0; m_we = 0;
    tag = "R1 reset";
    compare();

    step(1, 0);                               // R3: clean trap from reset
    load(6, 6, 0, 7, 0, 6'b101_011);          // R10
    step(1, 0);                               // R4
    step(1, 0);                               // R11: 7 -> 0
    step(1, 1);                               // R11: 0 -> 7, R6
    step(1, 1);                               // R6
    step(1, 1);                               // R5 R7: fill, type 3
    step(1, 2);                               // R8: cansave = N-2 -> spill
    step(0, 0);                               // R9: pulse ended
    load(7, 0, 3, 7, 2, 6'b101_011);
    step(1, 0);                               // R2 R7: 7 -> 1, type 5
    step(1, 2);                               // R8: no trap
    step(1, 1);                               // R6
    load(0, 2, 0, 5, 1, 6'b110_001);
    step(1, 1);                               // R5 R7: 0 -> 7, type 6
    step(0, 0);                               // R9

    for (int i = 0; i < 2000; i++) begin
      int sel = int'($urandom_range(0, 9));
      if (sel == 0) begin
        int s = int'($urandom_range(0, N - 2));
        int r = int'($urandom_range(0, N - 2 - s));
        load(int'($urandom_range(0, N - 1)), s, r, int'($urandom_range(0, N - 1)),
             int'($urandom_range(0, N - 1)), int'($urandom_range(0, 63)));
      end else if (sel == 1) step(0, 0);
      else step(1, int'($urandom_range(0, 2)));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule